// File: doc/BRIEF.md
# Four-Backplane Multiplexed LCD Drive Sequencer

This block drives a passive liquid-crystal panel that has four backplanes, at 1/4 duty and 1/2 bias. A host loads a small segment store with one row of segment bits per backplane. Row `r` belongs to backplane `r`. Bit `i` of a row is segment `i`, and a 1 means that pixel is on. While `en` is high, the block steps through the panel timing without further help. A prescaled tick counter produces two events in each half-slot: a data-load event and a blanking event. The blanking event also restarts the counter.

Each backplane slot holds two halves of equal length and opposite polarity. In the first half, the selected backplane is driven low and the segments carry the stored row. In the second half, the selected backplane is driven high and the segments carry the complement of the row. In both halves, the unselected backplanes are released so that they float to mid-supply. Each half ends with a window where every line is driven low. A backplane pin is a pair of bits: an output enable and a value. Enable 0 means the pin is released (mid level). Enable 1 means the pin is driven to the value. Segment pins share one enable. While the block is held in reset, and while `en` is low, every line is released.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset, and on every clock after an edge that samples `en` low, `seg_oe` is 0, `com_oe` is 0, and `seg_out` and `com_out` are 0. No line is driven.
- R2: After the first enabled edge and before the first load event, every line is driven low: `seg_oe`=1, `com_oe`=4'hF, all outputs 0.
- R3: Count enabled edges from 1. The counter ticks every PRE_DIV edges. The load event takes effect at edge (LOAD_AT+1)*PRE_DIV within a half. The blanking event takes effect at edge H=(BLANK_AT+1)*PRE_DIV, and the next half then starts.
- R4: In a first-polarity half, `com_oe` is one-hot on the selected backplane and `com_out` is 0. `seg_out` equals the stored row of that backplane.
- R5: In a second-polarity half, `seg_out` is the bitwise complement of the row. `com_out` is 1 on the selected backplane, and the other backplanes are released.
- R6: From each blanking event until the next load event, all lines are driven low.
- R7: The selected backplane starts at 0, advances by one only after the second-polarity half, and wraps from 3 to 0.
- R8: The polarity flag toggles at each load event and is cleared while `en` is low. The first load after any enable is first polarity.
- R9: A row write changes no output until the next load event. A half never changes part-way through.
- R10: For every pixel, the backplane level minus the segment level sums to zero over one slot when no row is rewritten during that slot. Levels are counted as released = 1, driven low = 0, driven high = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low releases all lines and restarts timing |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 2 | Row (backplane) to write |
| wr_data | input | SEG_N | Segment bits for the row, 1 = on |
| seg_oe | output | 1 | Segment line drive enable |
| seg_out | output | SEG_N | Segment line values |
| com_oe | output | 4 | Backplane drive enables, 0 = released to mid level |
| com_out | output | 4 | Backplane drive values |

## Verification
A wrong tick or compare count moves the load or blank edge away from its expected clock. The per-clock comparison flags this at the first misplaced edge, within one half-slot. A polarity or scan-index fault shows up as an inverted segment row or a wrong one-hot backplane at the next load. The per-slot voltage sum also catches it as a nonzero pixel average. A store or output register that follows writes too early changes `seg_out` part-way through a half on the very next clock.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;

  localparam int unsigned NUM_COM = 4;
  typedef logic [1:0] com_idx_t;
  typedef logic [NUM_COM-1:0] com_vec_t;

  // one-hot mask selecting a backplane
  function automatic com_vec_t com_select(input com_idx_t idx);
    com_vec_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // enables during a loaded half: only the selected line is driven
  function automatic com_vec_t com_enables_loaded(input com_idx_t idx);
    return com_select(idx);
  endfunction

  // values during a loaded half: selected line low first, high second
  function automatic com_vec_t com_values_loaded(input com_idx_t idx, input logic pol);
    return pol ? com_select(idx) : '0;
  endfunction

  // scan index step with wrap
  function automatic com_idx_t com_next(input com_idx_t idx);
    return (idx == com_idx_t'(NUM_COM-1)) ? '0 : idx + 2'd1;
  endfunction

endpackage

// File: rtl/lcd_tick_timer.sv
module lcd_tick_timer #(
  parameter int unsigned PRE_DIV  = 8,
  parameter int unsigned LOAD_AT  = 880,
  parameter int unsigned BLANK_AT = 1998
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic load_ev,
  output logic blank_ev
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int unsigned CW = $clog2(BLANK_AT + 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick     = run && (pre_q == PW'(PRE_DIV - 1));
  assign load_ev  = tick && (cnt_q == CW'(LOAD_AT));
  assign blank_ev = tick && (cnt_q == CW'(BLANK_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (blank_ev)  cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BLANK_AT)) else $error("count past blank compare"); // R3
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ev && blank_ev)) else $error("load and blank together"); // R3
  AST_BLANK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    blank_ev |=> (cnt_q == '0)) else $error("counter not restarted"); // R3

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcdmux_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     load_ev,
  output logic     pol,
  output com_idx_t idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= 1'b0;
      idx <= '0;
    end else if (!run) begin
      pol <= 1'b0;
      idx <= '0;
    end else if (load_ev) begin
      pol <= ~pol;
      if (pol) idx <= com_next(idx);
    end
  end

  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_ev) |=> (pol != $past(pol))) else $error("polarity stuck"); // R8
  AST_IDX_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_ev && !pol) |=> $stable(idx)) else $error("index moved early"); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_ev && pol) |=> (idx == $past(idx) + 2'd1)) else $error("index step"); // R7
  AST_POL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pol && idx == '0)) else $error("state not cleared"); // R8

endmodule

// File: rtl/lcd_seg_rows.sv
module lcd_seg_rows
  import lcdmux_pkg::*;
#(
  parameter int unsigned SEG_N = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  com_idx_t         wr_addr,
  input  logic [SEG_N-1:0] wr_data,
  input  com_idx_t         rd_idx,
  output logic [SEG_N-1:0] rd_row
);
  logic [SEG_N-1:0] rows [NUM_COM];

  for (genvar r = 0; r < NUM_COM; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 rows[r] <= '0;
      else if (wr_en && wr_addr == com_idx_t'(r)) rows[r] <= wr_data;
    end
  end

  assign rd_row = rows[rd_idx];

endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive
  import lcdmux_pkg::*;
#(
  parameter int unsigned SEG_N = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load_ev,
  input  logic             blank_ev,
  input  logic             pol,
  input  com_idx_t         idx,
  input  logic [SEG_N-1:0] row,
  output logic             seg_oe,
  output logic [SEG_N-1:0] seg_out,
  output com_vec_t         com_oe,
  output com_vec_t         com_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_oe  <= 1'b0;
      seg_out <= '0;
      com_oe  <= '0;
      com_out <= '0;
    end else if (!run) begin
      seg_oe  <= 1'b0;
      seg_out <= '0;
      com_oe  <= '0;
      com_out <= '0;
    end else if (blank_ev || !seg_oe) begin
      seg_oe  <= 1'b1;
      seg_out <= '0;
      com_oe  <= '1;
      com_out <= '0;
    end else if (load_ev) begin
      seg_oe  <= 1'b1;
      seg_out <= pol ? ~row : row;
      com_oe  <= com_enables_loaded(idx);
      com_out <= com_values_loaded(idx, pol);
    end
  end

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!seg_oe && com_oe == '0)) else $error("lines driven while idle"); // R1
  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && blank_ev) |=> (seg_oe && seg_out == '0 && com_oe == '1 && com_out == '0))
    else $error("blank not all low"); // R6
  AST_COM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_oe |-> ((com_oe == '1 && com_out == '0) ||
                ($countones(com_oe) == 1 && (com_out & ~com_oe) == '0)))
    else $error("backplane pattern"); // R4
  AST_SECOND_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_ev && pol && seg_oe) |=> (com_out == com_oe)) else $error("second half level"); // R5
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && seg_oe && !load_ev && !blank_ev) |=> (!seg_oe || $stable(seg_out)))
    else $error("segments changed mid-half"); // R9

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcdmux_pkg::*;
#(
  parameter int unsigned SEG_N    = 38,
  parameter int unsigned PRE_DIV  = 8,
  parameter int unsigned LOAD_AT  = 880,
  parameter int unsigned BLANK_AT = 1998
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [SEG_N-1:0] wr_data,
  output logic             seg_oe,
  output logic [SEG_N-1:0] seg_out,
  output logic [3:0]       com_oe,
  output logic [3:0]       com_out
);
  logic             load_ev;
  logic             blank_ev;
  logic             pol;
  com_idx_t         idx;
  logic [SEG_N-1:0] row;

  lcd_tick_timer #(.PRE_DIV(PRE_DIV), .LOAD_AT(LOAD_AT), .BLANK_AT(BLANK_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(en), .load_ev(load_ev), .blank_ev(blank_ev)
  );

  lcd_scan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(en), .load_ev(load_ev), .pol(pol), .idx(idx)
  );

  lcd_seg_rows #(.SEG_N(SEG_N)) u_rows (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(idx), .rd_row(row)
  );

  lcd_pin_drive #(.SEG_N(SEG_N)) u_pins (
    .clk(clk), .rst_n(rst_n), .run(en), .load_ev(load_ev), .blank_ev(blank_ev),
    .pol(pol), .idx(idx), .row(row),
    .seg_oe(seg_oe), .seg_out(seg_out), .com_oe(com_oe), .com_out(com_out)
  );

endmodule

// File: tb/lcd_mux_drive_test.sv
module lcd_mux_drive_test;
  localparam int SEG_N = 10;
  localparam int PD = 2, LA = 5, BA = 11;
  localparam int H  = (BA + 1) * PD;  // edges per half
  localparam int LP = (LA + 1) * PD;  // edge of load within half

  logic clk = 0, rst_n = 0, en = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [SEG_N-1:0] wr_data = 0;
  logic seg_oe;
  logic [SEG_N-1:0] seg_out;
  logic [3:0] com_oe, com_out;

  int errors = 0, checks = 0;
  int e = 0, loads = 0;
  logic [SEG_N-1:0] mem_m [4];
  logic [SEG_N-1:0] snap;
  int sums [4][SEG_N];
  bit dirty = 0;

  lcd_mux_drive #(.SEG_N(SEG_N), .PRE_DIV(PD), .LOAD_AT(LA), .BLANK_AT(BA)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seg_oe(seg_oe), .seg_out(seg_out), .com_oe(com_oe), .com_out(com_out));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at e=%0d", tag, what, act, exp, e);
    end
  endtask

  // behavioural reference: edge counter since enable plus a row snapshot at each load
  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0;
      for (int r = 0; r < 4; r++) mem_m[r] = '0;
      snap = '0;
    end else begin
      if (!en) e = 0;
      else begin
        e = e + 1;
        if (e % H == LP) snap = mem_m[((e / H) / 2) % 4];
      end
      if (wr_en) mem_m[wr_addr] = wr_data;
    end
  end

  function automatic int lvl(logic oe, logic v);
    return oe ? (v ? 2 : 0) : 1;
  endfunction

  always @(negedge clk) begin
    int h, pos, slot;
    logic pol;
    logic [SEG_N-1:0] es;
    h = e / H; pos = e % H; slot = (h / 2) % 4; pol = h[0];
    if (e == 0) begin
      check("R1", {seg_oe, com_oe}, 0, "oe released");
      check("R1", {seg_out, com_out}, 0, "values zero");
      loads = 0;
      for (int c = 0; c < 4; c++) for (int s = 0; s < SEG_N; s++) sums[c][s] = 0;
      dirty = 0;
    end else if (pos < LP) begin
      check(pos == 0 ? "R3" : (h == 0 ? "R2" : "R6"), {seg_oe, com_oe, com_out, seg_out},
            {1'b1, 4'hF, 4'h0, {SEG_N{1'b0}}}, "all low");
    end else begin
      es = pol ? ~snap : snap;
      check(pos == LP ? "R3" : (pol ? "R5" : "R4"), seg_out, es, "segments");
      check(pol ? "R5" : "R4", {seg_oe, com_oe, com_out},
            {1'b1, 4'b1 << slot, pol ? 4'b1 << slot : 4'h0}, "backplanes");
      if (pos == LP) begin
        check("R7", com_oe, 4'b1 << ((loads / 2) % 4), "scan index");
        loads++;
      end
    end
    if (e > 0) begin
      for (int c = 0; c < 4; c++) for (int s = 0; s < SEG_N; s++)
        sums[c][s] += lvl(com_oe[c], com_out[c]) - lvl(seg_oe, seg_out[s]);
      if (pos == 0 && h[0] == 1'b0 && h > 0) begin
        if (!dirty)
          for (int c = 0; c < 4; c++) for (int s = 0; s < SEG_N; s++)
            check("R10", 64'(sums[c][s]), 0, "pixel slot average");
        for (int c = 0; c < 4; c++) for (int s = 0; s < SEG_N; s++) sums[c][s] = 0;
        dirty = 0;
      end
    end
    if (wr_en) dirty = 1;
  end

  task automatic wr(int a, logic [SEG_N-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_pos(int p);
    @(negedge clk);
    while (!(en && e % H == p)) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [SEG_N-1:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    wr(0, 10'h3FF); wr(1, 10'h000); wr(2, 10'h2AA); wr(3, 10'h0F3);
    repeat (4) @(negedge clk);
    en = 1;
    repeat (2 * 8 * H) @(negedge clk);
    // R9: rewrite the active row inside a loaded half
    wait_pos(LP + 3);
    held = seg_out;
    wr(((e / H) / 2) % 4, ~mem_m[((e / H) / 2) % 4]);
    repeat (2) @(negedge clk);
    check("R9", seg_out, held, "held after write");
    repeat (3 * H) @(negedge clk);
    wr(1, 10'h155);
    repeat (8 * H) @(negedge clk);
    // R8: re-enable starts at first polarity, slot 0
    wait_pos(LP + 2);
    en = 0;
    repeat (6) @(negedge clk);
    en = 1;
    wait_pos(LP);
    check("R8", seg_out, mem_m[0], "first load after re-enable");
    check("R8", com_out, 4'h0, "selected low");
    repeat (8 * H + 5) @(negedge clk);
    en = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule